// File: doc/BRIEF.md
# Read Burst Timing Monitor

This block is a passive observer for the read side of a memory-mapped master port. It never drives the handshake signals it watches; it only samples the read-address and read-data channels. For every accepted read request it stamps the cycle of acceptance and holds the request in an in-order queue. Returned data is matched to that queue head-first, because read data for outstanding bursts comes back in the same order the addresses were accepted.

While a burst owns the read-data channel, the block sorts each of its cycles into one of three classes. A cycle is a transfer when valid and ready are both high. It is idle when the source has no beat (RVALID low), and this includes the case where both are low. It is a stall when a beat is offered but the sink holds it off. When the beat marked last is handed over, the block builds one summary record and presents it on a valid/ready port. The record carries the start address, the requested length, the acceptance cycle, the first and final cycles of the data phase, the three per-class cycle counts, and the number of cycles the burst sat in the queue.

A free-running counter gives all the timestamps. Two sticky flags report lost information: one is set when a request arrives while the queue is full, and the other is set when a record is produced while the previous record is still unread.

Top module: `rburst_timing_mon`

## Requirements
- R1: The accept stamp of a record equals the counter value in the cycle where the address valid and address ready inputs are both high. A cycle with valid high and ready low queues nothing.
- R2: Records leave in the order the addresses were accepted. Each record carries the address and length (the beat count minus one) sampled at acceptance.
- R3: The data-phase start equals the accept cycle when no other burst is outstanding at acceptance. Otherwise it is the cycle right after the preceding burst retires.
- R4: Every active cycle is classified and counted. Transfer (kind 0) is data valid and data ready both high. Idle (kind 1) is data valid low, whatever ready is. Stall (kind 2) is data valid high with ready low. The three counts sum to end minus start plus one.
- R5: The data-phase end is the cycle in which data valid, data ready and the last marker are all high. The record is presented with its valid output high from the next cycle.
- R6: The queue-wait field equals the data-phase start minus the accept stamp, in cycles.
- R7: The record's beat-error bit is 1 exactly when the transfer count differs from the length plus one.
- R8: An accepted address that arrives while QDEPTH requests are outstanding is dropped, and it raises the queue-overflow output. That output stays high until reset.
- R9: A presented record holds its value until taken with the ready input. A retirement that happens while an untaken record is pending is discarded, and it sets the record-lost output, which stays high until reset.
- R10: Data-channel activity while no burst is outstanding produces no record and changes no count.
- R11: After reset the record valid, queue-overflow and record-lost outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_valid | input | 1 | Observed read-address valid |
| ar_ready | input | 1 | Observed read-address ready |
| ar_addr | input | ADDR_W | Observed read-address |
| ar_len | input | LEN_W | Observed burst length (beats minus one) |
| r_valid | input | 1 | Observed read-data valid |
| r_ready | input | 1 | Observed read-data ready |
| r_last | input | 1 | Observed last-beat marker |
| rec_valid | output | 1 | Record present |
| rec_ready | input | 1 | Record taken |
| rec_addr | output | ADDR_W | Burst start address |
| rec_len | output | LEN_W | Requested length |
| rec_accept_ts | output | TS_W | Address-accept cycle |
| rec_start_ts | output | TS_W | First active data cycle |
| rec_end_ts | output | TS_W | Final active data cycle |
| rec_xfer_cnt | output | CNT_W | Transfer cycles |
| rec_idle_cnt | output | CNT_W | Idle cycles |
| rec_stall_cnt | output | CNT_W | Stall cycles |
| rec_wait | output | TS_W | Queue wait in cycles |
| rec_beat_err | output | 1 | Beat count differs from length |
| q_overflow | output | 1 | Sticky: request dropped, queue full |
| rec_lost | output | 1 | Sticky: record discarded, port busy |

## Verification
The stimulus opens with a lone burst that streams without holds, which pins down the basic stamping. Next come three addresses accepted in consecutive cycles, whose non-zero waits separate a correct queue from one that starts every burst at its acceptance. Idle-only, stall-only and both-low cycles are mixed so that each class has to land in its own counter. A short burst with a missing beat shows whether the length comparison works. A request that is accepted and retired in the same cycle, and a last beat that arrives with nothing outstanding, exercise the bypass edge and the ignore path. Directed runs then fill the queue past its depth and hold the record port busy, confirming that the right entry is dropped and that the earlier record stays put.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

   typedef enum logic [1:0] {
      BEAT_XFER  = 2'd0,
      BEAT_IDLE  = 2'd1,
      BEAT_STALL = 2'd2
   } beat_kind_e;

   // Both low counts as idle: the source is not offering anything.
   function automatic beat_kind_e classify_beat(input logic vld, input logic rdy);
      if (!vld)     return BEAT_IDLE;
      else if (rdy) return BEAT_XFER;
      else          return BEAT_STALL;
   endfunction

endpackage

// File: rtl/rbm_timestamp.sv
module rbm_timestamp #(
   parameter int TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] ts
);

   if (TS_W < 4) begin : g_bad_ts
      $error("rbm_timestamp: TS_W must be at least 4");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ts <= '0;
      else        ts <= ts + 1'b1;
   end

endmodule

// File: rtl/rbm_req_queue.sv
module rbm_req_queue #(
   parameter int ENTRY_W = 48,
   parameter int DEPTH   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic               pop,
   input  logic [ENTRY_W-1:0] wdata,
   output logic [ENTRY_W-1:0] rdata,
   output logic               empty,
   output logic               full
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("rbm_req_queue: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic               held_q;
      logic [ENTRY_W-1:0] slot_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            held_q <= 1'b0;
         end else if (push) begin
            held_q <= 1'b1;
         end else if (pop) begin
            held_q <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (push) slot_q <= wdata;
      end

      assign rdata = slot_q;
      assign empty = !held_q;
      assign full  = held_q;
   end else begin : g_ring
      localparam int PTR_W = $clog2(DEPTH);
      localparam int OCC_W = $clog2(DEPTH + 1);
      localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
      localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

      logic [ENTRY_W-1:0] store [DEPTH];
      logic [PTR_W-1:0]   wr_ptr, rd_ptr;
      logic [OCC_W-1:0]   occ;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
         end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
               2'b10:   occ <= occ + 1'b1;
               2'b01:   occ <= occ - 1'b1;
               default: occ <= occ;
            endcase
         end
      end

      always_ff @(posedge clk) begin
         if (push) store[wr_ptr] <= wdata;
      end

      assign rdata = store[rd_ptr];
      assign empty = (occ == '0);
      assign full  = (occ == FULL_OCC);
   end

endmodule

// File: rtl/rbm_phase_tracker.sv
module rbm_phase_tracker
   import rbm_pkg::*;
#(
   parameter int TS_W  = 32,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  ts,
   input  logic             head_valid,
   input  logic             r_valid,
   input  logic             r_ready,
   input  logic             r_last,
   output logic             retire,
   output logic [TS_W-1:0]  cur_start,
   output logic [CNT_W-1:0] cur_xfer,
   output logic [CNT_W-1:0] cur_idle,
   output logic [CNT_W-1:0] cur_stall
);

   logic             in_phase_q;
   logic [TS_W-1:0]  start_q;
   logic [CNT_W-1:0] xfer_q, idle_q, stall_q;
   logic             first_cyc;
   beat_kind_e       kind;

   assign kind      = classify_beat(r_valid, r_ready);
   assign first_cyc = head_valid && !in_phase_q;
   assign retire    = head_valid && r_valid && r_ready && r_last;

   // Totals including the present cycle, so a retiring cycle is counted.
   always_comb begin
      cur_start = first_cyc ? ts : start_q;
      cur_xfer  = (first_cyc ? '0 : xfer_q)  + CNT_W'(kind == BEAT_XFER);
      cur_idle  = (first_cyc ? '0 : idle_q)  + CNT_W'(kind == BEAT_IDLE);
      cur_stall = (first_cyc ? '0 : stall_q) + CNT_W'(kind == BEAT_STALL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_phase_q <= 1'b0;
         start_q    <= '0;
         xfer_q     <= '0;
         idle_q     <= '0;
         stall_q    <= '0;
      end else if (head_valid) begin
         in_phase_q <= !retire;
         start_q    <= cur_start;
         xfer_q     <= cur_xfer;
         idle_q     <= cur_idle;
         stall_q    <= cur_stall;
      end
   end

endmodule

// File: rtl/rburst_timing_mon.sv
module rburst_timing_mon #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8,
   parameter int TS_W   = 32,
   parameter int CNT_W  = 16,
   parameter int QDEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ar_valid,
   input  logic              ar_ready,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic [LEN_W-1:0]  ar_len,
   input  logic              r_valid,
   input  logic              r_ready,
   input  logic              r_last,
   output logic              rec_valid,
   input  logic              rec_ready,
   output logic [ADDR_W-1:0] rec_addr,
   output logic [LEN_W-1:0]  rec_len,
   output logic [TS_W-1:0]   rec_accept_ts,
   output logic [TS_W-1:0]   rec_start_ts,
   output logic [TS_W-1:0]   rec_end_ts,
   output logic [CNT_W-1:0]  rec_xfer_cnt,
   output logic [CNT_W-1:0]  rec_idle_cnt,
   output logic [CNT_W-1:0]  rec_stall_cnt,
   output logic [TS_W-1:0]   rec_wait,
   output logic              rec_beat_err,
   output logic              q_overflow,
   output logic              rec_lost
);

   localparam int ENTRY_W = ADDR_W + LEN_W + TS_W;

   if (CNT_W <= LEN_W) begin : g_bad_cnt
      $error("rburst_timing_mon: CNT_W must exceed LEN_W");
   end
   if (ADDR_W < 1 || LEN_W < 1) begin : g_bad_w
      $error("rburst_timing_mon: widths must be positive");
   end

   logic [TS_W-1:0]    ts;
   logic               ar_hs;
   logic               q_empty, q_full, q_push, q_pop;
   logic [ENTRY_W-1:0] in_entry, q_head;
   logic [ENTRY_W-1:0] head_entry;
   logic               head_valid;
   logic [ADDR_W-1:0]  head_addr;
   logic [LEN_W-1:0]   head_len;
   logic [TS_W-1:0]    head_acc;
   logic               retire;
   logic [TS_W-1:0]    cur_start;
   logic [CNT_W-1:0]   cur_xfer, cur_idle, cur_stall;
   logic               load_rec;

   rbm_timestamp #(.TS_W(TS_W)) u_ts (
      .clk   (clk),
      .rst_n (rst_n),
      .ts    (ts)
   );

   assign ar_hs    = ar_valid && ar_ready;
   assign in_entry = {ar_addr, ar_len, ts};

   // An empty queue lets the incoming request own the data channel at once.
   assign head_valid = !q_empty || ar_hs;
   assign head_entry = q_empty ? in_entry : q_head;
   assign {head_addr, head_len, head_acc} = head_entry;

   assign q_push = ar_hs && !q_full && !(q_empty && retire);
   assign q_pop  = retire && !q_empty;

   rbm_req_queue #(.ENTRY_W(ENTRY_W), .DEPTH(QDEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .pop   (q_pop),
      .wdata (in_entry),
      .rdata (q_head),
      .empty (q_empty),
      .full  (q_full)
   );

   rbm_phase_tracker #(.TS_W(TS_W), .CNT_W(CNT_W)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .ts         (ts),
      .head_valid (head_valid),
      .r_valid    (r_valid),
      .r_ready    (r_ready),
      .r_last     (r_last),
      .retire     (retire),
      .cur_start  (cur_start),
      .cur_xfer   (cur_xfer),
      .cur_idle   (cur_idle),
      .cur_stall  (cur_stall)
   );

   assign load_rec = retire && (!rec_valid || rec_ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_valid  <= 1'b0;
         q_overflow <= 1'b0;
         rec_lost   <= 1'b0;
      end else begin
         if (load_rec)       rec_valid <= 1'b1;
         else if (rec_ready) rec_valid <= 1'b0;
         if (ar_hs && q_full)                       q_overflow <= 1'b1;
         if (retire && rec_valid && !rec_ready)     rec_lost   <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_addr      <= '0;
         rec_len       <= '0;
         rec_accept_ts <= '0;
         rec_start_ts  <= '0;
         rec_end_ts    <= '0;
         rec_xfer_cnt  <= '0;
         rec_idle_cnt  <= '0;
         rec_stall_cnt <= '0;
         rec_wait      <= '0;
         rec_beat_err  <= 1'b0;
      end else if (load_rec) begin
         rec_addr      <= head_addr;
         rec_len       <= head_len;
         rec_accept_ts <= head_acc;
         rec_start_ts  <= cur_start;
         rec_end_ts    <= ts;
         rec_xfer_cnt  <= cur_xfer;
         rec_idle_cnt  <= cur_idle;
         rec_stall_cnt <= cur_stall;
         rec_wait      <= cur_start - head_acc;
         rec_beat_err  <= (cur_xfer != (CNT_W'(head_len) + 1'b1));
      end
   end

endmodule

// File: rtl/rbm_checker.sv
module rbm_checker #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8,
   parameter int TS_W   = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rec_valid,
   input logic              rec_ready,
   input logic [ADDR_W-1:0] rec_addr,
   input logic [LEN_W-1:0]  rec_len,
   input logic [TS_W-1:0]   rec_accept_ts,
   input logic [TS_W-1:0]   rec_start_ts,
   input logic [TS_W-1:0]   rec_end_ts,
   input logic [CNT_W-1:0]  rec_xfer_cnt,
   input logic [CNT_W-1:0]  rec_idle_cnt,
   input logic [CNT_W-1:0]  rec_stall_cnt,
   input logic [TS_W-1:0]   rec_wait,
   input logic              rec_beat_err,
   input logic              q_overflow,
   input logic              rec_lost
);

   logic [TS_W-1:0] cls_sum, span;
   assign cls_sum = TS_W'(rec_xfer_cnt) + TS_W'(rec_idle_cnt) + TS_W'(rec_stall_cnt);
   assign span    = rec_end_ts - rec_start_ts + 1'b1;

   // R4
   class_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> cls_sum == span);

   // R3
   start_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> (rec_start_ts >= rec_accept_ts) && (rec_end_ts >= rec_start_ts));

   // R6
   wait_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> rec_wait <= rec_end_ts - rec_accept_ts);

   // R7
   beat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !rec_beat_err |-> rec_xfer_cnt == CNT_W'(rec_len) + 1'b1);

   // R9
   rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !rec_ready |=> rec_valid && $stable(rec_addr) && $stable(rec_end_ts));

   // R9
   lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_lost |=> rec_lost);

   // R8
   no_overflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_overflow |=> q_overflow);

endmodule

bind rburst_timing_mon rbm_checker #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TS_W(TS_W), .CNT_W(CNT_W)
) u_rbm_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .rec_valid     (rec_valid),
   .rec_ready     (rec_ready),
   .rec_addr      (rec_addr),
   .rec_len       (rec_len),
   .rec_accept_ts (rec_accept_ts),
   .rec_start_ts  (rec_start_ts),
   .rec_end_ts    (rec_end_ts),
   .rec_xfer_cnt  (rec_xfer_cnt),
   .rec_idle_cnt  (rec_idle_cnt),
   .rec_stall_cnt (rec_stall_cnt),
   .rec_wait      (rec_wait),
   .rec_beat_err  (rec_beat_err),
   .q_overflow    (q_overflow),
   .rec_lost      (rec_lost)
);

// File: tb/rburst_timing_mon_tb_top.sv
module rburst_timing_mon_tb_top;

   localparam int ADDR_W = 32;
   localparam int LEN_W  = 8;
   localparam int TS_W   = 32;
   localparam int CNT_W  = 16;
   localparam int QDEPTH = 4;
   localparam int NSTIM  = 16;
   localparam int NREC   = 5;

   // {ar_valid, ar_ready, ar_len[7:0], r_valid, r_ready, r_last}
   localparam logic [12:0] STIM [NSTIM] = '{
      {1'b1, 1'b1, 8'd3, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0},
      {1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0},
      {1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0},
      {1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b1},
      {1'b1, 1'b1, 8'd1, 1'b0, 1'b0, 1'b0},
      {1'b1, 1'b1, 8'd0, 1'b1, 1'b0, 1'b0},
      {1'b1, 1'b1, 8'd1, 1'b1, 1'b1, 1'b0},
      {1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b1},
      {1'b0, 1'b0, 8'd0, 1'b0, 1'b1, 1'b0},
      {1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b1},
      {1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 1'b1},
      {1'b1, 1'b1, 8'd0, 1'b1, 1'b1, 1'b1},
      {1'b1, 1'b0, 8'd0, 1'b1, 1'b1, 1'b1},
      {1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0}
   };

   // Expected records, stamps relative to the first table cycle.
   localparam int EXP_ACC   [NREC] = '{0, 5, 6, 7, 13};
   localparam int EXP_START [NREC] = '{0, 5, 9, 11, 13};
   localparam int EXP_END   [NREC] = '{4, 8, 10, 12, 13};
   localparam int EXP_XFER  [NREC] = '{4, 2, 1, 1, 1};
   localparam int EXP_IDLE  [NREC] = '{1, 1, 1, 1, 0};
   localparam int EXP_STALL [NREC] = '{0, 1, 0, 0, 0};
   localparam int EXP_WAIT  [NREC] = '{0, 0, 3, 4, 0};
   localparam int EXP_LEN   [NREC] = '{3, 1, 0, 1, 0};
   localparam int EXP_ERR   [NREC] = '{0, 0, 0, 1, 0};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ar_valid = 1'b0, ar_ready = 1'b0;
   logic [ADDR_W-1:0] ar_addr = '0;
   logic [LEN_W-1:0]  ar_len = '0;
   logic              r_valid = 1'b0, r_ready = 1'b0, r_last = 1'b0;
   logic              rec_valid, rec_ready = 1'b1;
   logic [ADDR_W-1:0] rec_addr;
   logic [LEN_W-1:0]  rec_len;
   logic [TS_W-1:0]   rec_accept_ts, rec_start_ts, rec_end_ts, rec_wait;
   logic [CNT_W-1:0]  rec_xfer_cnt, rec_idle_cnt, rec_stall_cnt;
   logic              rec_beat_err, q_overflow, rec_lost;

   int  n_chk = 0;
   int  n_bad = 0;
   int  bench_cyc = 0;
   int  base = 0;
   int  midx = 0;
   int  rec_seen = 0;
   bit  tbl_on = 1'b0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   rburst_timing_mon #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TS_W(TS_W), .CNT_W(CNT_W), .QDEPTH(QDEPTH)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
      .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
      .rec_valid(rec_valid), .rec_ready(rec_ready),
      .rec_addr(rec_addr), .rec_len(rec_len),
      .rec_accept_ts(rec_accept_ts), .rec_start_ts(rec_start_ts), .rec_end_ts(rec_end_ts),
      .rec_xfer_cnt(rec_xfer_cnt), .rec_idle_cnt(rec_idle_cnt), .rec_stall_cnt(rec_stall_cnt),
      .rec_wait(rec_wait), .rec_beat_err(rec_beat_err),
      .q_overflow(q_overflow), .rec_lost(rec_lost)
   );

   always @(posedge clk) begin
      if (rst_n) bench_cyc <= bench_cyc + 1;
      if (rst_n && rec_valid && rec_ready) rec_seen <= rec_seen + 1;
   end

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input bit arv, input bit arr, input int addr, input int len,
                        input bit rv, input bit rr, input bit rl);
      @(negedge clk);
      ar_valid = arv;
      ar_ready = arr;
      ar_addr  = ADDR_W'(addr);
      ar_len   = LEN_W'(len);
      r_valid  = rv;
      r_ready  = rr;
      r_last   = rl;
   endtask

   // Record monitor for the table phase (ready held high).
   always @(negedge clk) begin
      if (tbl_on && rec_valid) begin
         if (midx >= NREC) begin
            chk("R10 extra record", 1, 0);
         end else begin
            chk("R2 addr",       rec_addr, 32'h1000 + 32'h40 * midx);
            chk("R2 len",        rec_len, EXP_LEN[midx]);
            chk("R1 accept",     rec_accept_ts, base + EXP_ACC[midx]);
            chk("R3 start",      rec_start_ts, base + EXP_START[midx]);
            chk("R5 end",        rec_end_ts, base + EXP_END[midx]);
            chk("R4 xfer",       rec_xfer_cnt, EXP_XFER[midx]);
            chk("R4 idle",       rec_idle_cnt, EXP_IDLE[midx]);
            chk("R4 stall",      rec_stall_cnt, EXP_STALL[midx]);
            chk("R6 wait",       rec_wait, EXP_WAIT[midx]);
            chk("R7 beat err",   rec_beat_err, EXP_ERR[midx]);
         end
         midx++;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int nb;
      int seen0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 rec_valid", rec_valid, 0);
      chk("R11 q_overflow", q_overflow, 0);
      chk("R11 rec_lost", rec_lost, 0);

      // Table walk
      nb = 0;
      for (int k = 0; k < NSTIM; k++) begin
         logic [12:0] s;
         s = STIM[k];
         @(negedge clk);
         if (k == 0) begin
            base   = bench_cyc;
            tbl_on = 1'b1;
         end
         ar_valid = s[12];
         ar_ready = s[11];
         ar_len   = s[10:3];
         ar_addr  = 32'h1000 + 32'h40 * nb;
         r_valid  = s[2];
         r_ready  = s[1];
         r_last   = s[0];
         if (s[12] && s[11]) nb++;
      end
      drive(0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      tbl_on = 1'b0;
      // R10: stray last beat with nothing outstanding made no record
      chk("R10 record count", midx, NREC);

      // R8: five accepts into a depth-4 queue, no data returned
      for (int k = 0; k < 5; k++) drive(1, 1, 32'h2000 + 16 * k, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      chk("R8 overflow set", q_overflow, 1);
      seen0 = rec_seen;
      for (int k = 0; k < 4; k++) drive(0, 0, 0, 0, 1, 1, 1);
      @(negedge clk);
      chk("R2 last drained addr", rec_addr, 32'h2030);
      drive(0, 0, 0, 0, 0, 0, 0);
      repeat (2) @(negedge clk);
      chk("R8 dropped request", rec_seen - seen0, 4);
      chk("R8 overflow sticky", q_overflow, 1);
      chk("R11 lost still low", rec_lost, 0);

      // R9: port busy, second retirement discarded
      rec_ready = 1'b0;
      drive(1, 1, 32'h3000, 0, 1, 1, 1);
      drive(0, 0, 0, 0, 0, 0, 0);
      drive(1, 1, 32'h3100, 0, 1, 1, 1);
      drive(0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      chk("R9 lost set", rec_lost, 1);
      chk("R9 pending held", rec_valid, 1);
      chk("R9 pending addr", rec_addr, 32'h3000);
      rec_ready = 1'b1;
      @(negedge clk);
      chk("R9 taken", rec_valid, 0);
      chk("R9 lost sticky", rec_lost, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule